// File: doc/BRIEF.md
# Optimal Host Tile Predictor

This block decides where a shared cache block should live on a 4x4 tiled mesh. Every access to a block arrives as one event that carries the requesting tile, the block's current sharer vector (one bit per tile), its access counter and the tile that hosts it now. The block sets the requester's bit and advances the counter. When the counter reaches the programmable migration level, it scores every tile as a possible host instead. The score of a tile is the round-trip router hops that all recorded sharers would spend to reach it.

Scoring is sequential: one candidate tile per cycle, so a decision takes 16 cycles, and the busy flag is high for that time. At the end the block returns a cleared sharer vector and counter, so that a new pattern starts to build. It raises a migrate request only when the winning tile differs from the current host. The data movement, the network and the cache arrays are outside this block.

Top module: `mhp_host_predictor`

## Requirements
- R1: After reset, `busy_o`, `upd_valid_o` and `mig_req_o` are 0.
- R2: An accepted access that does not trigger produces, on the next cycle, a one-cycle `upd_valid_o`. It returns `upd_pat_o` = `acc_pat_i` with bit `acc_tile_i` set (bit i stands for tile i) and `upd_cnt_o` = `acc_cnt_i`+1, with `mig_req_o` = 0 and `busy_o` = 0.
- R3: An access triggers when `acc_cnt_i`+1 is greater than or equal to the effective level. The effective level is the 5-bit `mig_level_i`, except that a value of 0 selects the default level 10 and values above 16 act as 16.
- R4: Tile ID t sits at column t mod 4 and row t div 4. For a candidate host, a sharer on another tile costs 2*(|dcol|+|drow|+1) hops and a sharer on the host itself costs 0. The chosen host has the smallest sum over the sharer vector that includes the requester. With sharers 0 and 6, hosts 3, 15, 2 and 0 cost 14, 22, 10 and 8.
- R5: Among tiles that share the minimum cost, the current host wins when it is one of them; otherwise the lowest tile ID wins.
- R6: A triggering access sets `busy_o` from the next cycle on for exactly 16 cycles. The result then appears as a one-cycle `upd_valid_o` in the cycle in which `busy_o` has fallen.
- R7: The result of a triggering access returns `upd_pat_o` = 0 and `upd_cnt_o` = 0, whether or not the block moves.
- R8: `mig_req_o` is raised together with the triggered result only when the chosen host differs from `cur_host_i` as sampled at the trigger. `mig_host_o` carries the chosen host.
- R9: An access presented while `busy_o` is 1 is ignored. It neither alters the pending decision nor produces an update.
- R10: An access whose requester bit is already set leaves the sharer vector unchanged and still advances the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access event strobe |
| acc_tile_i | input | 4 | Requesting tile ID |
| acc_pat_i | input | 16 | Block's current sharer vector |
| acc_cnt_i | input | 4 | Block's current access counter |
| cur_host_i | input | 4 | Tile currently hosting the block |
| mig_level_i | input | 5 | Migration level setting (0 selects default) |
| busy_o | output | 1 | Candidate evaluation in progress |
| upd_valid_o | output | 1 | Updated vector and counter are valid |
| upd_pat_o | output | 16 | Updated sharer vector |
| upd_cnt_o | output | 4 | Updated access counter |
| mig_req_o | output | 1 | Migrate request strobe |
| mig_host_o | output | 4 | Chosen host tile ID |

## Verification
The bench builds the block with its default parameters: a 4x4 mesh, a 4-bit counter, a 5-bit level field and a default level of 10. With these values the highest level of 16 is reached only when a counter of 15 rolls over to 16, so that edge is checked, along with a level of 31 clamping to 16 and a level of 0 falling back to 10. The 16-bit vector also brings within reach the case where every tile is a sharer, in which four centre tiles tie. It also covers the corner pair 0 and 15 and the two-sharer tie of tiles 0 and 6, so both branches of the tie-break rule are exercised.

// File: rtl/mhp_pkg.sv
package mhp_pkg;

    // Absolute difference of two grid coordinates
    function automatic int unsigned mhp_span(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Round-trip router hops between two distinct tiles (routers on the path, both ways)
    function automatic int unsigned mhp_trip(input int unsigned dcol, input int unsigned drow);
        return 2 * (dcol + drow + 1);
    endfunction

endpackage

// File: rtl/mhp_access_merge.sv
module mhp_access_merge #(
    parameter int unsigned NT        = 16,
    parameter int unsigned ID_W      = 4,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned LVL_W     = 5,
    parameter int unsigned DEF_LEVEL = 10
) (
    input  logic [ID_W-1:0]  tile_i,
    input  logic [NT-1:0]    pat_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [NT-1:0]    pat_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fire_o
);
    localparam int unsigned MAX_LEVEL = 2 ** CNT_W;
    localparam logic [NT-1:0] ONE_HOT0 = {{(NT-1){1'b0}}, 1'b1};

    int unsigned lvl_raw;
    int unsigned lvl_eff;
    int unsigned cnt_next;

    always_comb begin
        pat_o    = pat_i | (ONE_HOT0 << tile_i);
        cnt_o    = cnt_i + {{(CNT_W-1){1'b0}}, 1'b1};
        lvl_raw  = 32'(level_i);
        if (lvl_raw == 0) begin
            lvl_eff = DEF_LEVEL;
        end else if (lvl_raw > MAX_LEVEL) begin
            lvl_eff = MAX_LEVEL;
        end else begin
            lvl_eff = lvl_raw;
        end
        cnt_next = 32'(cnt_i) + 1;
        fire_o   = (cnt_next >= lvl_eff);
    end

endmodule

// File: rtl/mhp_hop_cost.sv
module mhp_hop_cost
    import mhp_pkg::*;
#(
    parameter int unsigned MESH_X = 4,
    parameter int unsigned MESH_Y = 4,
    parameter int unsigned ID_W   = 4,
    parameter int unsigned COST_W = 8
) (
    input  logic [MESH_X*MESH_Y-1:0] sharers_i,
    input  logic [ID_W-1:0]          cand_i,
    output logic [COST_W-1:0]        cost_o
);
    localparam int unsigned NT = MESH_X * MESH_Y;

    logic [COST_W-1:0] term [NT];

    for (genvar t = 0; t < NT; t++) begin : g_term
        localparam int unsigned TCOL = t % MESH_X;
        localparam int unsigned TROW = t / MESH_X;
        int unsigned ccol;
        int unsigned crow;
        always_comb begin
            ccol = 32'(cand_i) % MESH_X;
            crow = 32'(cand_i) / MESH_X;
            if (sharers_i[t] && (cand_i != ID_W'(t))) begin
                term[t] = COST_W'(mhp_trip(mhp_span(ccol, TCOL), mhp_span(crow, TROW)));
            end else begin
                term[t] = '0;
            end
        end
    end

    always_comb begin
        cost_o = '0;
        for (int i = 0; i < NT; i++) begin
            cost_o = cost_o + term[i];
        end
    end

endmodule

// File: rtl/mhp_host_predictor.sv
module mhp_host_predictor #(
    parameter int unsigned MESH_X    = 4,
    parameter int unsigned MESH_Y    = 4,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned LVL_W     = 5,
    parameter int unsigned DEF_LEVEL = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              acc_valid_i,
    input  logic [$clog2(MESH_X*MESH_Y)-1:0]  acc_tile_i,
    input  logic [MESH_X*MESH_Y-1:0]          acc_pat_i,
    input  logic [CNT_W-1:0]                  acc_cnt_i,
    input  logic [$clog2(MESH_X*MESH_Y)-1:0]  cur_host_i,
    input  logic [LVL_W-1:0]                  mig_level_i,
    output logic                              busy_o,
    output logic                              upd_valid_o,
    output logic [MESH_X*MESH_Y-1:0]          upd_pat_o,
    output logic [CNT_W-1:0]                  upd_cnt_o,
    output logic                              mig_req_o,
    output logic [$clog2(MESH_X*MESH_Y)-1:0]  mig_host_o
);
    localparam int unsigned NT       = MESH_X * MESH_Y;
    localparam int unsigned ID_W     = $clog2(NT);
    localparam int unsigned MAX_HOPS = 2 * (MESH_X + MESH_Y - 1);
    localparam int unsigned COST_W   = $clog2(NT * MAX_HOPS + 1);
    localparam logic [ID_W-1:0] LAST_ID = ID_W'(NT - 1);

    typedef struct packed {
        logic              busy;
        logic [ID_W-1:0]   idx;
        logic [NT-1:0]     pat;
        logic [ID_W-1:0]   cur;
        logic [COST_W-1:0] best_cost;
        logic [ID_W-1:0]   best_id;
        logic [COST_W-1:0] cur_cost;
        logic              upd_valid;
        logic [NT-1:0]     upd_pat;
        logic [CNT_W-1:0]  upd_cnt;
        logic              mig_req;
        logic [ID_W-1:0]   mig_host;
    } state_t;

    state_t s_d, s_q;

    logic [NT-1:0]     merged_pat;
    logic [CNT_W-1:0]  merged_cnt;
    logic              fire;
    logic [COST_W-1:0] cand_cost;
    logic [COST_W-1:0] nb_cost;
    logic [ID_W-1:0]   nb_id;
    logic [COST_W-1:0] ncur_cost;
    logic [ID_W-1:0]   final_host;

    mhp_access_merge #(
        .NT        (NT),
        .ID_W      (ID_W),
        .CNT_W     (CNT_W),
        .LVL_W     (LVL_W),
        .DEF_LEVEL (DEF_LEVEL)
    ) u_merge (
        .tile_i  (acc_tile_i),
        .pat_i   (acc_pat_i),
        .cnt_i   (acc_cnt_i),
        .level_i (mig_level_i),
        .pat_o   (merged_pat),
        .cnt_o   (merged_cnt),
        .fire_o  (fire)
    );

    mhp_hop_cost #(
        .MESH_X (MESH_X),
        .MESH_Y (MESH_Y),
        .ID_W   (ID_W),
        .COST_W (COST_W)
    ) u_cost (
        .sharers_i (s_q.pat),
        .cand_i    (s_q.idx),
        .cost_o    (cand_cost)
    );

    always_comb begin
        s_d           = s_q;
        s_d.upd_valid = 1'b0;
        s_d.mig_req   = 1'b0;

        // Running minimum after the candidate of this cycle (strict: lowest ID keeps ties)
        if (cand_cost < s_q.best_cost) begin
            nb_cost = cand_cost;
            nb_id   = s_q.idx;
        end else begin
            nb_cost = s_q.best_cost;
            nb_id   = s_q.best_id;
        end
        ncur_cost  = (s_q.idx == s_q.cur) ? cand_cost : s_q.cur_cost;
        final_host = (ncur_cost == nb_cost) ? s_q.cur : nb_id;

        if (!s_q.busy) begin
            if (acc_valid_i) begin
                if (fire) begin
                    s_d.busy      = 1'b1;
                    s_d.idx       = '0;
                    s_d.pat       = merged_pat;
                    s_d.cur       = cur_host_i;
                    s_d.best_cost = '1;
                    s_d.best_id   = '0;
                    s_d.cur_cost  = '1;
                end else begin
                    s_d.upd_valid = 1'b1;
                    s_d.upd_pat   = merged_pat;
                    s_d.upd_cnt   = merged_cnt;
                    s_d.mig_host  = cur_host_i;
                end
            end
        end else begin
            s_d.best_cost = nb_cost;
            s_d.best_id   = nb_id;
            s_d.cur_cost  = ncur_cost;
            s_d.idx       = s_q.idx + {{(ID_W-1){1'b0}}, 1'b1};
            if (s_q.idx == LAST_ID) begin
                s_d.busy      = 1'b0;
                s_d.idx       = '0;
                s_d.upd_valid = 1'b1;
                s_d.upd_pat   = '0;
                s_d.upd_cnt   = '0;
                s_d.mig_req   = (final_host != s_q.cur);
                s_d.mig_host  = final_host;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = s_q.busy;
    assign upd_valid_o = s_q.upd_valid;
    assign upd_pat_o   = s_q.upd_pat;
    assign upd_cnt_o   = s_q.upd_cnt;
    assign mig_req_o   = s_q.mig_req;
    assign mig_host_o  = s_q.mig_host;

endmodule

// File: rtl/mhp_host_predictor_chk.sv
module mhp_host_predictor_chk #(
    parameter int unsigned NT    = 16,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid_i,
    input logic             busy_o,
    input logic             upd_valid_o,
    input logic [NT-1:0]    upd_pat_o,
    input logic [CNT_W-1:0] upd_cnt_o,
    input logic             mig_req_o
);
    localparam int unsigned RUN_W = $clog2(NT + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + {{(RUN_W-1){1'b0}}, 1'b1};
        end else begin
            run_q <= '0;
        end
    end

    // R7
    clear_on_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && mig_req_o) |-> (upd_pat_o == '0 && upd_cnt_o == '0));

    // R8
    req_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req_o |-> upd_valid_o);

    // R6
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < RUN_W'(NT)));

    // R6
    finish_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (upd_valid_o && upd_pat_o == '0 && upd_cnt_o == '0));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !busy_o) |=> (busy_o || upd_valid_o));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !upd_valid_o);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && !$past(busy_o)) |-> (upd_cnt_o != '0 && !mig_req_o));

endmodule

bind mhp_host_predictor mhp_host_predictor_chk #(
    .NT    (NT),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid_i),
    .busy_o      (busy_o),
    .upd_valid_o (upd_valid_o),
    .upd_pat_o   (upd_pat_o),
    .upd_cnt_o   (upd_cnt_o),
    .mig_req_o   (mig_req_o)
);

// File: tb/mhp_host_predictor_bench.sv
`timescale 1ns/1ps
module mhp_host_predictor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic [3:0]  acc_tile_i = '0;
    logic [15:0] acc_pat_i = '0;
    logic [3:0]  acc_cnt_i = '0;
    logic [3:0]  cur_host_i = '0;
    logic [4:0]  mig_level_i = '0;
    logic        busy_o;
    logic        upd_valid_o;
    logic [15:0] upd_pat_o;
    logic [3:0]  upd_cnt_o;
    logic        mig_req_o;
    logic [3:0]  mig_host_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mhp_host_predictor u_mhp_host_predictor (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid_i),
        .acc_tile_i  (acc_tile_i),
        .acc_pat_i   (acc_pat_i),
        .acc_cnt_i   (acc_cnt_i),
        .cur_host_i  (cur_host_i),
        .mig_level_i (mig_level_i),
        .busy_o      (busy_o),
        .upd_valid_o (upd_valid_o),
        .upd_pat_o   (upd_pat_o),
        .upd_cnt_o   (upd_cnt_o),
        .mig_req_o   (mig_req_o),
        .mig_host_o  (mig_host_o)
    );

    typedef struct packed {
        logic [3:0]  tile;
        logic [15:0] pat;
        logic [3:0]  cnt;
        logic [3:0]  cur;
        logic [4:0]  lvl;
        logic        trig;
        logic [15:0] xpat;
        logic [3:0]  xcnt;
        logic        xreq;
        logic [3:0]  xhost;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{4'd6,  16'h0001, 4'd8,  4'd5,  5'd10, 1'b0, 16'h0041, 4'd9,  1'b0, 4'd5},
        '{4'd6,  16'h0001, 4'd9,  4'd3,  5'd10, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd0},
        '{4'd6,  16'h0001, 4'd9,  4'd6,  5'd10, 1'b1, 16'h0000, 4'd0,  1'b0, 4'd6},
        '{4'd9,  16'h0000, 4'd9,  4'd0,  5'd10, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd9},
        '{4'd14, 16'h0000, 4'd14, 4'd0,  5'd16, 1'b0, 16'h4000, 4'd15, 1'b0, 4'd0},
        '{4'd14, 16'h0000, 4'd15, 4'd0,  5'd16, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd14},
        '{4'd3,  16'h0000, 4'd9,  4'd7,  5'd0,  1'b1, 16'h0000, 4'd0,  1'b1, 4'd3},
        '{4'd3,  16'h0000, 4'd8,  4'd7,  5'd0,  1'b0, 16'h0008, 4'd9,  1'b0, 4'd7},
        '{4'd2,  16'h0000, 4'd15, 4'd5,  5'd31, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd2},
        '{4'd2,  16'h0000, 4'd14, 4'd5,  5'd31, 1'b0, 16'h0004, 4'd15, 1'b0, 4'd5},
        '{4'd0,  16'h0001, 4'd2,  4'd0,  5'd10, 1'b0, 16'h0001, 4'd3,  1'b0, 4'd0},
        '{4'd0,  16'hFFFF, 4'd9,  4'd0,  5'd10, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd5},
        '{4'd0,  16'hFFFF, 4'd9,  4'd10, 5'd10, 1'b1, 16'h0000, 4'd0,  1'b0, 4'd10},
        '{4'd15, 16'h0001, 4'd9,  4'd15, 5'd10, 1'b1, 16'h0000, 4'd0,  1'b0, 4'd15},
        '{4'd15, 16'h0001, 4'd9,  4'd6,  5'd10, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd0},
        '{4'd4,  16'h0000, 4'd0,  4'd4,  5'd1,  1'b1, 16'h0000, 4'd0,  1'b0, 4'd4},
        '{4'd5,  16'h0000, 4'd12, 4'd5,  5'd10, 1'b1, 16'h0000, 4'd0,  1'b0, 4'd5},
        '{4'd2,  16'h0003, 4'd9,  4'd12, 5'd10, 1'b1, 16'h0000, 4'd0,  1'b1, 4'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        acc_tile_i  = v.tile;
        acc_pat_i   = v.pat;
        acc_cnt_i   = v.cnt;
        cur_host_i  = v.cur;
        mig_level_i = v.lvl;
        acc_valid_i = 1'b1;
    endtask

    // Drives one access and checks the outcome; trigger rows wait the full evaluation window
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        apply(v);
        @(negedge clk);
        acc_valid_i = 1'b0;
        if (!v.trig) begin
            check("R3 no trigger busy", 32'(busy_o), 32'd0);
            check("R2 update strobe", 32'(upd_valid_o), 32'd1);
            check("R2 R10 pattern", 32'(upd_pat_o), 32'(v.xpat));
            check("R2 counter", 32'(upd_cnt_o), 32'(v.xcnt));
            check("R2 no request", 32'(mig_req_o), 32'd0);
        end else begin
            check("R3 trigger busy", 32'(busy_o), 32'd1);
            check("R6 no early result", 32'(upd_valid_o), 32'd0);
            repeat (15) @(negedge clk);
            check("R6 busy in last cycle", 32'(busy_o), 32'd1);
            @(negedge clk);
            check("R6 busy fallen", 32'(busy_o), 32'd0);
            check("R6 result strobe", 32'(upd_valid_o), 32'd1);
            check("R7 pattern cleared", 32'(upd_pat_o), 32'd0);
            check("R7 counter cleared", 32'(upd_cnt_o), 32'd0);
            check("R8 request", 32'(mig_req_o), 32'(v.xreq));
            check("R4 R5 chosen host", 32'(mig_host_o), 32'(v.xhost));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy in reset", 32'(busy_o), 32'd0);
        check("R1 strobe in reset", 32'(upd_valid_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy_o), 32'd0);
        check("R1 strobe after reset", 32'(upd_valid_o), 32'd0);
        check("R1 request after reset", 32'(mig_req_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(TBL[i]);
        end

        // R10: repeated requester leaves vector intact, counter still advances
        run_vec('{4'd7, 16'h0880, 4'd4, 4'd2, 5'd10, 1'b0, 16'h0880, 4'd5, 1'b0, 4'd2});

        // R9: accesses during evaluation are ignored
        @(negedge clk);
        apply(TBL[1]);
        @(negedge clk);
        acc_tile_i  = 4'd15;
        acc_pat_i   = 16'h8000;
        acc_cnt_i   = 4'd9;
        cur_host_i  = 4'd15;
        repeat (5) @(negedge clk);
        check("R9 busy during ignored access", 32'(busy_o), 32'd1);
        check("R9 no update while busy", 32'(upd_valid_o), 32'd0);
        acc_valid_i = 1'b0;
        repeat (11) @(negedge clk);
        check("R9 result strobe", 32'(upd_valid_o), 32'd1);
        check("R9 host unchanged by ignored access", 32'(mig_host_o), 32'd0);
        check("R9 request unchanged by ignored access", 32'(mig_req_o), 32'd1);
        @(negedge clk);
        check("R9 no extra update", 32'(upd_valid_o), 32'd0);
        check("R9 idle after result", 32'(busy_o), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule